// File: doc/BRIEF.md
# Lockable GPIO Control Register Bank

This block is the software-visible register file of a 32-pin general-purpose I/O controller. It stores the per-pin configuration: inversion, output data, output enable, open-drain type, pull resistors, input mask, event type and edge selection, event enables, slew and drive strength, plus blink, mux and debounce words that are kept but have no effect. Every configuration word is presented on an output port, so the neighbouring pin and event logic works from registered values. Event status bits are raised by that event logic through a set vector and cleared by software with write-one-to-clear.

Output data, output enable and event enable each have a pair of write-only alias words. One alias ORs a mask into the register and the other clears the masked bits, so a single pin can change without a read-modify-write. A global write lock protects the whole bank. Any write to either lock word engages the lock. Releasing it needs two writes: the second key goes into the upper lock word, then the first key goes into the lower lock word. The bus is a one-cycle word port in a 4 KiB window, and read data is registered.

Top module: `gpio_lock_bank`

## Requirements
- R1: After reset, every register and output is 0 except pull-up, pull-down, slew and drive, which take the parameters PU_RST, PD_RST, SLEW_RST and DRV_RST. The bank is unlocked after reset.
- R2: A full write to a read-write word stores the value, and a later read returns it. The read-write words are 0x08 inversion, 0x0C data-out, 0x10 enable, 0x14 open-drain, 0x18 mux, 0x1C pull-up, 0x20 pull-down, 0x24 debounce, 0x28 event type, 0x2C both-edge, 0x30..0x3C blink, 0x40 event enable, 0x58 input mask, 0x5C slew and 0x60 drive. Each configuration word appears on its output port from the cycle after the write.
- R3: A write to 0x68 ORs the value into data-out, and a write to 0x6C clears the data-out bits that are set in the value.
- R4: Writes to 0x70 and 0x74 apply the same set and clear rule to output enable.
- R5: Writes to 0x44 and 0x48 apply the same set and clear rule to event enable.
- R6: Each event status bit (0x4C) becomes 1 in the cycle after its evt_set_i bit is high, and it stays 1 until a write to 0x4C with that bit at 1. If a set and a clear of the same bit arrive together, the set wins.
- R7: The alias words, the upper lock word 0x7C and the words 0x50 and 0x54 all read 0. Word 0x04 reads pin_din_i, and writes to it have no effect.
- R8: While the bank is unlocked, a write of any value to 0x00 or 0x7C locks it. After that, 0x00 reads 1 and locked_o is 1.
- R9: While the bank is locked, writes to every word other than 0x00 and 0x7C leave all registers unchanged. This includes the alias words and the status clear.
- R10: While the bank is locked, a write to 0x7C stores the value. A write of 0xC0DEFA73 to 0x00 unlocks the bank only if the stored value is 0xC0DE1248, and unlocking sets both lock words to 0. Any other write to 0x00 leaves the bank locked.
- R11: An access is accepted only when be is 4'hF and address bits [1:0] are 0. Other accesses do not change anything and read 0. Addresses above 0x7C read 0 and writes to them have no effect.
- R12: Read data appears on bus_rdata_o one cycle after an accepted read. In every other cycle bus_rdata_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_addr_i | input | ADDR_W | Byte address in the window |
| bus_be_i | input | 4 | Byte enables; must be all ones |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| pin_din_i | input | 32 | Sampled pin inputs, read at 0x04 |
| evt_set_i | input | 32 | Event status set requests |
| locked_o | output | 1 | Bank is write-protected |
| pol_o | output | 32 | Inversion |
| dout_o | output | 32 | Output data |
| oe_o | output | 32 | Output enable |
| otyp_o | output | 32 | Open-drain type |
| pu_o | output | 32 | Pull-up enable |
| pd_o | output | 32 | Pull-down enable |
| iem_o | output | 32 | Input mask |
| evtyp_o | output | 32 | Event type (edge or level) |
| evbe_o | output | 32 | Both-edge select |
| even_o | output | 32 | Event enable |
| evst_o | output | 32 | Event status |
| slew_o | output | 32 | Slew-rate select |
| drv_o | output | 32 | Drive-strength select |

## Verification
The set and clear aliases are tested with masks that overlap the current register value and with masks that do not. This separates an OR or AND-NOT update from a plain overwrite. The unlock sequence is tried with the wrong first key, the wrong second key, and then both keys correct. Only the last case must release the bank, which separates a check on both keys from a check on one. Event status is tested with set and clear on different bits and then on the same bit in the same cycle, which shows that the set has priority. Partial byte enables, misaligned addresses and out-of-window addresses are sent against a known register value to show that such accesses are filtered out.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int DW     = 32;
  localparam int NWORDS = 32;

  localparam int IDX_LOCKA    = 0;
  localparam int IDX_DIN      = 1;
  localparam int IDX_POL      = 2;
  localparam int IDX_DOUT     = 3;
  localparam int IDX_OE       = 4;
  localparam int IDX_OTYP     = 5;
  localparam int IDX_MUX      = 6;
  localparam int IDX_PU       = 7;
  localparam int IDX_PD       = 8;
  localparam int IDX_DBNC     = 9;
  localparam int IDX_EVTYP    = 10;
  localparam int IDX_EVBE     = 11;
  localparam int IDX_BLINK0   = 12;
  localparam int NBLINK       = 4;
  localparam int IDX_EVEN     = 16;
  localparam int IDX_EVEN_SET = 17;
  localparam int IDX_EVEN_CLR = 18;
  localparam int IDX_EVST     = 19;
  localparam int IDX_IEM      = 22;
  localparam int IDX_SLEW     = 23;
  localparam int IDX_DRV      = 24;
  localparam int IDX_DOUT_SET = 26;
  localparam int IDX_DOUT_CLR = 27;
  localparam int IDX_OE_SET   = 28;
  localparam int IDX_OE_CLR   = 29;
  localparam int IDX_LOCKB    = 31;

  localparam logic [DW-1:0] UNLOCK_KEY_A = 32'hC0DE_FA73;
  localparam logic [DW-1:0] UNLOCK_KEY_B = 32'hC0DE_1248;

  // Word holds plain read-write storage.
  function automatic bit is_store(int i);
    return (i >= IDX_POL && i <= IDX_EVBE) ||
           (i >= IDX_BLINK0 && i < IDX_BLINK0 + NBLINK) ||
           i == IDX_EVEN || i == IDX_IEM || i == IDX_SLEW || i == IDX_DRV;
  endfunction

  function automatic int set_alias(int i);
    case (i)
      IDX_DOUT: return IDX_DOUT_SET;
      IDX_OE:   return IDX_OE_SET;
      IDX_EVEN: return IDX_EVEN_SET;
      default:  return -1;
    endcase
  endfunction

  function automatic int clr_alias(int i);
    case (i)
      IDX_DOUT: return IDX_DOUT_CLR;
      IDX_OE:   return IDX_OE_CLR;
      IDX_EVEN: return IDX_EVEN_CLR;
      default:  return -1;
    endcase
  endfunction
endpackage

// File: rtl/gpio_bank_decode.sv
module gpio_bank_decode #(
  parameter int ADDR_W = 12,
  parameter int NW     = 32,
  localparam int IW    = $clog2(NW)
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [3:0]        be_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output logic [NW-1:0]     wr_hit_o,
  output logic              rd_ok_o,
  output logic [IW-1:0]     idx_o
);
  logic aligned;
  logic in_win;

  assign aligned = (be_i == 4'hF) && (addr_i[1:0] == 2'b00);
  assign in_win  = (addr_i[ADDR_W-1:IW+2] == '0);
  assign idx_o   = addr_i[IW+1:2];
  assign rd_ok_o = rd_i && aligned && in_win;

  for (genvar g = 0; g < NW; g++) begin : g_hit
    assign wr_hit_o[g] = wr_i && aligned && in_win && (idx_o == IW'(g));
  end
endmodule

// File: rtl/gpio_setclr_reg.sv
module gpio_setclr_reg #(
  parameter int            W   = 32,
  parameter logic [W-1:0]  RST = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_full_i,
  input  logic         wr_set_i,
  input  logic         wr_clr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (rst)            q_o <= RST;
    else if (wr_full_i) q_o <= wdata_i;
    else if (wr_set_i)  q_o <= q_o | wdata_i;
    else if (wr_clr_i)  q_o <= q_o & ~wdata_i;
  end
endmodule

// File: rtl/gpio_lock_ctrl.sv
module gpio_lock_ctrl
  import gpio_bank_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_a_i,
  input  logic          wr_b_i,
  input  logic [DW-1:0] wdata_i,
  output logic          locked_o,
  output logic [DW-1:0] key_b_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      locked_o <= 1'b0;
      key_b_o  <= '0;
    end else if (!locked_o) begin
      if (wr_a_i || wr_b_i) begin
        locked_o <= 1'b1;
        key_b_o  <= '0;
      end
    end else if (wr_b_i) begin
      key_b_o <= wdata_i;
    end else if (wr_a_i && wdata_i == UNLOCK_KEY_A && key_b_o == UNLOCK_KEY_B) begin
      locked_o <= 1'b0;
      key_b_o  <= '0;
    end
  end
endmodule

// File: rtl/gpio_lock_bank.sv
module gpio_lock_bank
  import gpio_bank_pkg::*;
#(
  parameter int            ADDR_W   = 12,
  parameter logic [31:0]   PU_RST   = '0,
  parameter logic [31:0]   PD_RST   = '0,
  parameter logic [31:0]   SLEW_RST = '0,
  parameter logic [31:0]   DRV_RST  = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [3:0]        bus_be_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  input  logic [31:0]       pin_din_i,
  input  logic [31:0]       evt_set_i,
  output logic              locked_o,
  output logic [31:0]       pol_o,
  output logic [31:0]       dout_o,
  output logic [31:0]       oe_o,
  output logic [31:0]       otyp_o,
  output logic [31:0]       pu_o,
  output logic [31:0]       pd_o,
  output logic [31:0]       iem_o,
  output logic [31:0]       evtyp_o,
  output logic [31:0]       evbe_o,
  output logic [31:0]       even_o,
  output logic [31:0]       evst_o,
  output logic [31:0]       slew_o,
  output logic [31:0]       drv_o
);
  localparam int IW = $clog2(NWORDS);

  logic [NWORDS-1:0] wr_hit;
  logic [NWORDS-1:0] wr_eff;
  logic              rd_ok;
  logic [IW-1:0]     idx;
  logic [DW-1:0]     lock_key_b;
  logic [DW-1:0]     store_q [NWORDS];
  logic [DW-1:0]     evst_q;
  logic [DW-1:0]     rd_mux;

  gpio_bank_decode #(.ADDR_W(ADDR_W), .NW(NWORDS)) u_dec (
    .addr_i   (bus_addr_i),
    .be_i     (bus_be_i),
    .wr_i     (bus_wr_i),
    .rd_i     (bus_rd_i),
    .wr_hit_o (wr_hit),
    .rd_ok_o  (rd_ok),
    .idx_o    (idx)
  );

  gpio_lock_ctrl u_lock (
    .clk      (clk),
    .rst      (rst),
    .wr_a_i   (wr_hit[IDX_LOCKA]),
    .wr_b_i   (wr_hit[IDX_LOCKB]),
    .wdata_i  (bus_wdata_i),
    .locked_o (locked_o),
    .key_b_o  (lock_key_b)
  );

  // Lock gates every write except the two lock words.
  assign wr_eff = locked_o ? '0 : wr_hit;

  for (genvar g = 0; g < NWORDS; g++) begin : g_word
    if (is_store(g)) begin : g_reg
      localparam int SI = set_alias(g);
      localparam int CI = clr_alias(g);
      localparam logic [DW-1:0] RV = (g == IDX_PU)   ? PU_RST   :
                                     (g == IDX_PD)   ? PD_RST   :
                                     (g == IDX_SLEW) ? SLEW_RST :
                                     (g == IDX_DRV)  ? DRV_RST  : '0;
      logic ws;
      logic wc;
      if (SI >= 0) begin : g_alias
        assign ws = wr_eff[SI];
        assign wc = wr_eff[CI];
      end else begin : g_plain
        assign ws = 1'b0;
        assign wc = 1'b0;
      end
      gpio_setclr_reg #(.W(DW), .RST(RV)) u_reg (
        .clk       (clk),
        .rst       (rst),
        .wr_full_i (wr_eff[g]),
        .wr_set_i  (ws),
        .wr_clr_i  (wc),
        .wdata_i   (bus_wdata_i),
        .q_o       (store_q[g])
      );
    end else begin : g_none
      assign store_q[g] = '0;
    end
  end

  // Status: hardware set has priority over a software clear.
  always_ff @(posedge clk) begin
    if (rst) evst_q <= '0;
    else     evst_q <= (evst_q & ~({DW{wr_eff[IDX_EVST]}} & bus_wdata_i)) | evt_set_i;
  end

  always_comb begin
    case (idx)
      IW'(IDX_LOCKA): rd_mux = {{(DW-1){1'b0}}, locked_o};
      IW'(IDX_DIN):   rd_mux = pin_din_i;
      IW'(IDX_EVST):  rd_mux = evst_q;
      default:        rd_mux = store_q[idx];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata_o <= '0;
    else     bus_rdata_o <= rd_ok ? rd_mux : '0;
  end

  assign pol_o   = store_q[IDX_POL];
  assign dout_o  = store_q[IDX_DOUT];
  assign oe_o    = store_q[IDX_OE];
  assign otyp_o  = store_q[IDX_OTYP];
  assign pu_o    = store_q[IDX_PU];
  assign pd_o    = store_q[IDX_PD];
  assign iem_o   = store_q[IDX_IEM];
  assign evtyp_o = store_q[IDX_EVTYP];
  assign evbe_o  = store_q[IDX_EVBE];
  assign even_o  = store_q[IDX_EVEN];
  assign evst_o  = evst_q;
  assign slew_o  = store_q[IDX_SLEW];
  assign drv_o   = store_q[IDX_DRV];
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr_i,
  input logic              bus_rd_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [3:0]        bus_be_i,
  input logic [31:0]       bus_wdata_i,
  input logic [31:0]       bus_rdata_o,
  input logic [31:0]       evt_set_i,
  input logic              locked_o,
  input logic [31:0]       dout_o,
  input logic [31:0]       oe_o,
  input logic [31:0]       evst_o,
  input logic [31:0]       lock_key_b
);
  logic full_wr;
  assign full_wr = bus_wr_i && bus_be_i == 4'hF;

  // R8
  lock_engage_chk: assert property (@(posedge clk) disable iff (rst)
    (!locked_o && full_wr && bus_addr_i == '0) |=> locked_o);

  // R9
  locked_dout_chk: assert property (@(posedge clk) disable iff (rst)
    (locked_o && full_wr && (bus_addr_i == ADDR_W'(IDX_DOUT*4) ||
     bus_addr_i == ADDR_W'(IDX_DOUT_SET*4) || bus_addr_i == ADDR_W'(IDX_DOUT_CLR*4)))
    |=> $stable(dout_o));

  // R9
  locked_oe_chk: assert property (@(posedge clk) disable iff (rst)
    (locked_o && full_wr && bus_addr_i == ADDR_W'(IDX_OE_SET*4)) |=> $stable(oe_o));

  // R10
  unlock_key_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(locked_o) |-> $past(full_wr && bus_addr_i == '0 &&
      bus_wdata_i == UNLOCK_KEY_A && lock_key_b == UNLOCK_KEY_B));

  // R6
  evst_source_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((evst_o & ~$past(evst_o) & ~$past(evt_set_i)) == '0));

  // R6
  evst_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((~evst_o & $past(evt_set_i)) == '0));

  // R7
  alias_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd_i && bus_addr_i == ADDR_W'(IDX_DOUT_SET*4)) |=> bus_rdata_o == '0);

  // R11
  partial_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd_i && bus_be_i != 4'hF) |=> bus_rdata_o == '0);

  // R12
  idle_rdata_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd_i |=> bus_rdata_o == '0);
endmodule

bind gpio_lock_bank gpio_bank_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .bus_wr_i    (bus_wr_i),
  .bus_rd_i    (bus_rd_i),
  .bus_addr_i  (bus_addr_i),
  .bus_be_i    (bus_be_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_rdata_o (bus_rdata_o),
  .evt_set_i   (evt_set_i),
  .locked_o    (locked_o),
  .dout_o      (dout_o),
  .oe_o        (oe_o),
  .evst_o      (evst_o),
  .lock_key_b  (lock_key_b)
);

// File: tb/tb_gpio_lock_bank.sv
module tb_gpio_lock_bank;
  localparam logic [31:0] PU_R = 32'h0000_00F0;
  localparam logic [31:0] PD_R = 32'h0F00_0000;
  localparam logic [31:0] SL_R = 32'h1234_0000;
  localparam logic [31:0] DR_R = 32'h0000_5678;

  logic clk = 0, rst = 1;
  logic bus_wr = 0, bus_rd = 0;
  logic [11:0] addr = '0;
  logic [3:0]  be = 4'hF;
  logic [31:0] wdata = '0, rdata, pin_din = '0, evt_set = '0;
  logic locked;
  logic [31:0] pol, dout, oe, otyp, pu, pd, iem, evtyp, evbe, even, evst, slew, drv;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  gpio_lock_bank #(.PU_RST(PU_R), .PD_RST(PD_R), .SLEW_RST(SL_R), .DRV_RST(DR_R)) dut (
    .clk(clk), .rst(rst), .bus_wr_i(bus_wr), .bus_rd_i(bus_rd), .bus_addr_i(addr),
    .bus_be_i(be), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .pin_din_i(pin_din),
    .evt_set_i(evt_set), .locked_o(locked), .pol_o(pol), .dout_o(dout), .oe_o(oe),
    .otyp_o(otyp), .pu_o(pu), .pd_o(pd), .iem_o(iem), .evtyp_o(evtyp), .evbe_o(evbe),
    .even_o(even), .evst_o(evst), .slew_o(slew), .drv_o(drv));

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] b = 4'hF);
    @(negedge clk);
    bus_wr = 1; addr = a; wdata = d; be = b;
    @(negedge clk);
    bus_wr = 0; be = 4'hF;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d, input logic [3:0] b = 4'hF);
    @(negedge clk);
    bus_rd = 1; addr = a; be = b;
    @(negedge clk);
    d = rdata;
    bus_rd = 0; be = 4'hF;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    check("R1 dout", dout, 0);
    check("R1 oe", oe, 0);
    check("R1 pu", pu, PU_R);
    check("R1 pd", pd, PD_R);
    check("R1 slew", slew, SL_R);
    check("R1 drv", drv, DR_R);
    check("R1 locked", {31'b0, locked}, 0);
    rd(12'h05C, v); check("R1 slew read", v, SL_R);
  endtask

  task automatic t_plain_rw;
    logic [31:0] v;
    wr(12'h008, 32'hA5A5_0001); check("R2 pol port", pol, 32'hA5A5_0001);
    wr(12'h058, 32'h0000_FFFF); check("R2 iem port", iem, 32'h0000_FFFF);
    wr(12'h028, 32'h00FF_00FF); check("R2 evtyp port", evtyp, 32'h00FF_00FF);
    wr(12'h038, 32'h1357_9BDF);
    rd(12'h038, v); check("R2 blink read", v, 32'h1357_9BDF);
    wr(12'h024, 32'h2468_ACE0);
    rd(12'h024, v); check("R2 debounce read", v, 32'h2468_ACE0);
    rd(12'h008, v); check("R2 pol read", v, 32'hA5A5_0001);
    // R12: read data is cleared in the idle cycle after a read
    @(negedge clk); check("R12 idle rdata", rdata, 0);
  endtask

  task automatic t_dout_alias;
    wr(12'h00C, 32'h0000_00F0);
    wr(12'h068, 32'h0000_0F10); check("R3 dout set", dout, 32'h0000_0FF0);
    wr(12'h06C, 32'h0000_0330); check("R3 dout clr", dout, 32'h0000_0CC0);
  endtask

  task automatic t_oe_alias;
    wr(12'h010, 32'h8000_0001);
    wr(12'h070, 32'h0000_0006); check("R4 oe set", oe, 32'h8000_0007);
    wr(12'h074, 32'h8000_0002); check("R4 oe clr", oe, 32'h0000_0005);
  endtask

  task automatic t_even_alias;
    logic [31:0] v;
    wr(12'h040, 32'h0000_1100);
    wr(12'h044, 32'h0000_0011); check("R5 even set", even, 32'h0000_1111);
    wr(12'h048, 32'h0000_1001); check("R5 even clr", even, 32'h0000_0110);
    rd(12'h044, v); check("R7 even set alias reads 0", v, 0);
  endtask

  task automatic t_evst;
    @(negedge clk); evt_set = 32'h0000_0003;
    @(negedge clk); evt_set = 0;
    check("R6 evst set", evst, 32'h0000_0003);
    @(negedge clk); check("R6 evst holds", evst, 32'h0000_0003);
    wr(12'h04C, 32'h0000_0002); check("R6 evst w1c", evst, 32'h0000_0001);
    @(negedge clk);
    bus_wr = 1; addr = 12'h04C; wdata = 32'h1; evt_set = 32'h1;
    @(negedge clk);
    bus_wr = 0; evt_set = 0;
    check("R6 set beats clear", evst, 32'h0000_0001);
    wr(12'h04C, 32'h1); check("R6 evst cleared", evst, 0);
  endtask

  task automatic t_readonly;
    logic [31:0] v;
    pin_din = 32'hDEAD_BEEF;
    wr(12'h004, 32'h0);
    rd(12'h004, v); check("R7 din read", v, 32'hDEAD_BEEF);
    rd(12'h068, v); check("R7 dout set alias reads 0", v, 0);
    wr(12'h050, 32'hFFFF_FFFF);
    rd(12'h050, v); check("R7 pin-lock word reads 0", v, 0);
    rd(12'h07C, v); check("R7 lock word B reads 0", v, 0);
  endtask

  task automatic t_filter;
    logic [31:0] v;
    wr(12'h00C, 32'h1111_2222);
    wr(12'h00C, 32'hFFFF_FFFF, 4'h3); check("R11 partial write", dout, 32'h1111_2222);
    wr(12'h00E, 32'hFFFF_FFFF); check("R11 misaligned write", dout, 32'h1111_2222);
    wr(12'h10C, 32'hFFFF_FFFF); check("R11 out-of-window write", dout, 32'h1111_2222);
    rd(12'h00C, v, 4'h1); check("R11 partial read", v, 0);
    rd(12'h10C, v); check("R11 unmapped read", v, 0);
  endtask

  task automatic t_lock;
    logic [31:0] v;
    wr(12'h07C, 32'h1234_5678); check("R8 lock via B", {31'b0, locked}, 1);
    rd(12'h000, v); check("R8 lock A reads 1", v, 1);
    // R9: everything but lock words ignored
    wr(12'h00C, 32'h0); wr(12'h068, 32'hFFFF_FFFF); wr(12'h074, 32'hFFFF_FFFF);
    check("R9 dout frozen", dout, 32'h1111_2222);
    check("R9 oe frozen", oe, 32'h0000_0005);
    @(negedge clk); evt_set = 32'h8; @(negedge clk); evt_set = 0;
    wr(12'h04C, 32'h8); check("R9 evst clear ignored", evst, 32'h8);
    // R10: wrong keys
    wr(12'h07C, 32'hC0DE_1248); wr(12'h000, 32'hC0DE_FA72);
    check("R10 wrong key A", {31'b0, locked}, 1);
    wr(12'h07C, 32'hC0DE_1249); wr(12'h000, 32'hC0DE_FA73);
    check("R10 wrong key B", {31'b0, locked}, 1);
    wr(12'h07C, 32'hC0DE_1248); wr(12'h000, 32'hC0DE_FA73);
    check("R10 unlock", {31'b0, locked}, 0);
    rd(12'h000, v); check("R10 lock A cleared", v, 0);
    wr(12'h000, 32'h0); check("R8 lock via A", {31'b0, locked}, 1);
    wr(12'h07C, 32'hC0DE_1248); wr(12'h000, 32'hC0DE_FA73);
    wr(12'h00C, 32'h0000_0042); check("R10 writable after unlock", dout, 32'h0000_0042);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_plain_rw();
    t_dout_alias();
    t_oe_alias();
    t_even_alias();
    t_evst();
    t_readonly();
    t_filter();
    t_lock();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule